// File: doc/BRIEF.md
# Machine Check and Parity Control Unit

This unit sits between a processor's configuration bits and its bus interface. It decides what happens when one of three error sources fires: an external machine-check pin, a parity mismatch on an incoming bus address, or a parity mismatch on incoming bus data. Each source has its own enable bit. An enabled error becomes either a one-cycle, recoverable machine-check exception request or a permanent checkstop. The machine-check-enable bit of the machine state register makes that choice: 1 gives the exception, 0 gives the checkstop.

The unit also produces even parity for outgoing address and data bytes. A separate enable bit controls this generation. When generation is disabled, the outgoing parity lanes sit at zero. Incoming parity is checked only on cycles where the matching valid strobe is high.

The checkstop is sticky until reset. Once it is set, no further exception requests are issued.

Top module: `mcpc_unit`

## Requirements
- R1: After reset, `mcReq` and `checkstop` are 0.
- R2: With `cfgParGen`=1, each parity output bit `i` equals the XOR of byte `i` (bits 8i+7..8i) of `addrOut` or `dataOut`. The parity outputs are combinational in the same cycle.
- R3: With `cfgParGen`=0, `addrParOut` and `dataParOut` are all zero whatever the outgoing data.
- R4: With `cfgMcpEn`=0, a rise of `mcpIn` produces neither an `mcReq` pulse nor a checkstop.
- R5: With `cfgMcpEn`=1 and `msrMe`=1, a rise of `mcpIn` gives exactly one `mcReq` pulse of one cycle. The rise is seen at clock edge k (low at k-1, high at k), and `mcReq` is high in the cycle after edge k+1. Holding `mcpIn` high longer gives no further pulses.
- R6: With `cfgMcpEn`=1 and `msrMe`=0, a rise of `mcpIn` sets `checkstop` after edge k+1 and gives no `mcReq`.
- R7: An address parity error is raised when `addrValid`=1 and `cfgAddrChk`=1 at edge k, and some lane bit of `addrParIn` differs from the XOR of its byte of `addrIn`. It is routed like R5/R6 with the same latency: `mcReq` if `msrMe`=1, `checkstop` if `msrMe`=0.
- R8: A bad address parity is ignored when `cfgAddrChk`=0 or `addrValid`=0: neither `mcReq` nor `checkstop` results.
- R9: Data parity errors follow R7 and R8 with `dataIn`, `dataParIn`, `dataValid` and `cfgDataChk`.
- R10: `checkstop` stays 1 until reset, and `mcReq` stays 0 while it is set.
- R11: Several enabled sources firing at the same edge give a single one-cycle `mcReq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMcpEn | input | 1 | Enable for the external machine-check pin |
| cfgParGen | input | 1 | Enable for outgoing parity generation |
| cfgAddrChk | input | 1 | Enable for address parity checking |
| cfgDataChk | input | 1 | Enable for data parity checking |
| msrMe | input | 1 | Machine-check-enable state: 1 exception, 0 checkstop |
| mcpIn | input | 1 | External machine-check pin, edge detected |
| addrOut | input | 32 | Outgoing address |
| dataOut | input | 64 | Outgoing data |
| addrParOut | output | 4 | Generated address parity, one bit per byte |
| dataParOut | output | 8 | Generated data parity, one bit per byte |
| addrIn | input | 32 | Incoming address |
| addrParIn | input | 4 | Incoming address parity |
| addrValid | input | 1 | Incoming address is valid this cycle |
| dataIn | input | 64 | Incoming data |
| dataParIn | input | 8 | Incoming data parity |
| dataValid | input | 1 | Incoming data is valid this cycle |
| mcReq | output | 1 | One-cycle machine-check exception request |
| checkstop | output | 1 | Sticky checkstop |

## Verification
Some properties are checked by the assertions on every cycle:
- the generated parity keeps each outgoing word plus its parity bits at even weight;
- a detected parity error always goes back to a valid strobe;
- no cycle without an event changes `mcReq` or `checkstop`;
- the checkstop never clears;
- `mcReq` and `checkstop` are never high together.

Other behaviours can only be shown by the bench's scenarios. These are the exact latency of the routing, the choice between pulse and checkstop by `msrMe`, the masking by each enable bit, the single pulse for a held pin, and the merging of simultaneous sources.

// File: rtl/mcpc_pkg.sv
package mcpc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic genEn;
    logic addrChkEn;
    logic dataChkEn;
  } ctrlStrobe_t;

  // Registered error flags from datapath to control
  typedef struct packed {
    logic addrErr;
    logic dataErr;
  } parErr_t;

endpackage

// File: rtl/mcpc_datapath.sv
module mcpc_datapath
  import mcpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [ADDR_W-1:0]     addrOut,
  input  logic [DATA_W-1:0]     dataOut,
  output logic [ADDR_W/8-1:0]   addrParOut,
  output logic [DATA_W/8-1:0]   dataParOut,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic [ADDR_W/8-1:0]   addrParIn,
  input  logic                  addrValid,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [DATA_W/8-1:0]   dataParIn,
  input  logic                  dataValid,
  output parErr_t               errs
);

  localparam int ADDR_LANES = ADDR_W / 8;
  localparam int DATA_LANES = DATA_W / 8;

  logic [ADDR_LANES-1:0] addrLaneBad;
  logic [DATA_LANES-1:0] dataLaneBad;

  // Per-lane even parity: parity bit is the XOR of the byte
  for (genvar i = 0; i < ADDR_LANES; i++) begin : gAddrLane
    assign addrParOut[i]  = strb.genEn & (^addrOut[8*i +: 8]);
    assign addrLaneBad[i] = (^addrIn[8*i +: 8]) ^ addrParIn[i];
  end

  for (genvar i = 0; i < DATA_LANES; i++) begin : gDataLane
    assign dataParOut[i]  = strb.genEn & (^dataOut[8*i +: 8]);
    assign dataLaneBad[i] = (^dataIn[8*i +: 8]) ^ dataParIn[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errs <= '0;
    end else begin
      errs.addrErr <= strb.addrChkEn & addrValid & (|addrLaneBad);
      errs.dataErr <= strb.dataChkEn & dataValid & (|dataLaneBad);
    end
  end

  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    strb.genEn |-> (((^addrOut) == (^addrParOut)) && ((^dataOut) == (^dataParOut)))); // R2

  AST_ADDR_ERR_VALID: assert property (@(posedge clk) disable iff (!rstN)
    errs.addrErr |-> $past(addrValid)); // R8

  AST_DATA_ERR_VALID: assert property (@(posedge clk) disable iff (!rstN)
    errs.dataErr |-> $past(dataValid)); // R9

endmodule

// File: rtl/mcpc_control.sv
module mcpc_control
  import mcpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgMcpEn,
  input  logic        cfgParGen,
  input  logic        cfgAddrChk,
  input  logic        cfgDataChk,
  input  logic        msrMe,
  input  logic        mcpIn,
  input  parErr_t     errs,
  output ctrlStrobe_t strb,
  output logic        mcReq,
  output logic        checkstop
);

  logic mcpPrev;
  logic mcpRiseQ;
  logic errEvent;

  assign strb.genEn     = cfgParGen;
  assign strb.addrChkEn = cfgAddrChk;
  assign strb.dataChkEn = cfgDataChk;

  // All sources merge into one event per cycle
  assign errEvent = mcpRiseQ | errs.addrErr | errs.dataErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcpPrev   <= 1'b1;
      mcpRiseQ  <= 1'b0;
      mcReq     <= 1'b0;
      checkstop <= 1'b0;
    end else begin
      mcpPrev   <= mcpIn;
      mcpRiseQ  <= cfgMcpEn & mcpIn & ~mcpPrev;
      mcReq     <= errEvent & msrMe & ~checkstop;
      checkstop <= checkstop | (errEvent & ~msrMe);
    end
  end

  AST_QUIET_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (!mcpRiseQ && !errs.addrErr && !errs.dataErr) |=> (!mcReq && $stable(checkstop))); // R4

  AST_CHECKSTOP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |=> checkstop); // R10

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(mcReq && checkstop)); // R10

endmodule

// File: rtl/mcpc_unit.sv
module mcpc_unit
  import mcpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgMcpEn,
  input  logic                cfgParGen,
  input  logic                cfgAddrChk,
  input  logic                cfgDataChk,
  input  logic                msrMe,
  input  logic                mcpIn,
  input  logic [ADDR_W-1:0]   addrOut,
  input  logic [DATA_W-1:0]   dataOut,
  output logic [ADDR_W/8-1:0] addrParOut,
  output logic [DATA_W/8-1:0] dataParOut,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [ADDR_W/8-1:0] addrParIn,
  input  logic                addrValid,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [DATA_W/8-1:0] dataParIn,
  input  logic                dataValid,
  output logic                mcReq,
  output logic                checkstop
);

  ctrlStrobe_t strb;
  parErr_t     errs;

  mcpc_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMcpEn   (cfgMcpEn),
    .cfgParGen  (cfgParGen),
    .cfgAddrChk (cfgAddrChk),
    .cfgDataChk (cfgDataChk),
    .msrMe      (msrMe),
    .mcpIn      (mcpIn),
    .errs       (errs),
    .strb       (strb),
    .mcReq      (mcReq),
    .checkstop  (checkstop)
  );

  mcpc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addrOut    (addrOut),
    .dataOut    (dataOut),
    .addrParOut (addrParOut),
    .dataParOut (dataParOut),
    .addrIn     (addrIn),
    .addrParIn  (addrParIn),
    .addrValid  (addrValid),
    .dataIn     (dataIn),
    .dataParIn  (dataParIn),
    .dataValid  (dataValid),
    .errs       (errs)
  );

endmodule

// File: tb/mcpc_unit_test.sv
module mcpc_unit_test;

  localparam int AW = 32;
  localparam int DW = 64;
  localparam int AL = AW / 8;
  localparam int DL = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMcpEn = 0, cfgParGen = 0, cfgAddrChk = 0, cfgDataChk = 0, msrMe = 0, mcpIn = 0;
  logic [AW-1:0] addrOut = '0, addrIn = '0;
  logic [DW-1:0] dataOut = '0, dataIn = '0;
  logic [AL-1:0] addrParIn = '0, addrParOut;
  logic [DL-1:0] dataParIn = '0, dataParOut;
  logic addrValid = 0, dataValid = 0;
  logic mcReq, checkstop;

  int checks = 0;
  int errors = 0;
  bit csModel = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  mcpc_unit uut (
    .clk(clk), .rstN(rstN), .cfgMcpEn(cfgMcpEn), .cfgParGen(cfgParGen),
    .cfgAddrChk(cfgAddrChk), .cfgDataChk(cfgDataChk), .msrMe(msrMe), .mcpIn(mcpIn),
    .addrOut(addrOut), .dataOut(dataOut), .addrParOut(addrParOut), .dataParOut(dataParOut),
    .addrIn(addrIn), .addrParIn(addrParIn), .addrValid(addrValid),
    .dataIn(dataIn), .dataParIn(dataParIn), .dataValid(dataValid),
    .mcReq(mcReq), .checkstop(checkstop)
  );

  function automatic logic [AL-1:0] addrPar(input logic [AW-1:0] v);
    logic [AL-1:0] p;
    for (int i = 0; i < AL; i++) p[i] = ^v[8*i +: 8];
    return p;
  endfunction

  function automatic logic [DL-1:0] dataPar(input logic [DW-1:0] v);
    logic [DL-1:0] p;
    for (int i = 0; i < DL; i++) p[i] = ^v[8*i +: 8];
    return p;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    mcpIn = 0; addrValid = 0; dataValid = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    csModel = 0;
    @(negedge clk);
  endtask

  // Drives one stimulus cycle, checks generated parity at once and routing two edges later
  task automatic runCase(input string tag, input bit me, input bit mEn, input bit aChk,
                         input bit dChk, input bit gen, input bit mcp, input bit aVal,
                         input bit aBad, input bit dVal, input bit dBad);
    bit ev;
    bit expReq;
    logic [AL-1:0] aMask;
    logic [DL-1:0] dMask;
    @(negedge clk);
    msrMe = me; cfgMcpEn = mEn; cfgAddrChk = aChk; cfgDataChk = dChk; cfgParGen = gen;
    addrOut = $urandom; dataOut = {$urandom, $urandom};
    addrIn = $urandom; dataIn = {$urandom, $urandom};
    aMask = AL'(($urandom % 15) + 1);
    dMask = DL'(($urandom % 255) + 1);
    addrParIn = addrPar(addrIn) ^ (aBad ? aMask : '0);
    dataParIn = dataPar(dataIn) ^ (dBad ? dMask : '0);
    addrValid = aVal; dataValid = dVal; mcpIn = mcp;
    #1;
    check(gen ? "R2 addr parity" : "R3 addr parity off", 64'(addrParOut),
          gen ? 64'(addrPar(addrOut)) : 64'd0);
    check(gen ? "R2 data parity" : "R3 data parity off", 64'(dataParOut),
          gen ? 64'(dataPar(dataOut)) : 64'd0);
    ev = (mEn & mcp) | (aChk & aVal & aBad) | (dChk & dVal & dBad);
    if (csModel) expReq = 0;
    else begin
      expReq = ev & me;
      csModel = ev & ~me;
    end
    @(negedge clk);
    mcpIn = 0; addrValid = 0; dataValid = 0;
    @(negedge clk);
    check({tag, " mcReq"}, 64'(mcReq), 64'(expReq));
    check({tag, " checkstop"}, 64'(checkstop), 64'(csModel));
    @(negedge clk);
    check({tag, " R11 pulse width"}, 64'(mcReq), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    doReset();
    check("R1 mcReq reset", 64'(mcReq), 64'd0);
    check("R1 checkstop reset", 64'(checkstop), 64'd0);

    // Directed cases
    runCase("R4 mcp masked me1", 1, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    runCase("R4 mcp masked me0", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    runCase("R5 mcp exception", 1, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    runCase("R7 addr err exception", 1, 0, 1, 0, 1, 0, 1, 1, 0, 0);
    runCase("R8 addr chk off", 0, 0, 0, 1, 1, 0, 1, 1, 0, 0);
    runCase("R8 addr not valid", 0, 0, 1, 1, 1, 0, 0, 1, 0, 0);
    runCase("R9 data err exception", 1, 0, 0, 1, 0, 0, 0, 0, 1, 1);
    runCase("R9 data chk off", 0, 0, 1, 0, 1, 0, 0, 0, 1, 1);
    runCase("R9 data not valid", 0, 1, 1, 1, 1, 0, 0, 0, 0, 1);
    runCase("R11 all sources", 1, 1, 1, 1, 1, 1, 1, 1, 1, 1);

    // R5: held pin gives one pulse only
    @(negedge clk);
    msrMe = 1; cfgMcpEn = 1; mcpIn = 1;
    @(negedge clk);
    @(negedge clk);
    check("R5 held pin first pulse", 64'(mcReq), 64'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R5 held pin no repeat", 64'(mcReq), 64'd0);
    end
    mcpIn = 0;
    @(negedge clk);

    runCase("R6 mcp checkstop", 0, 1, 0, 0, 1, 1, 0, 0, 0, 0);
    runCase("R10 sticky no req", 1, 1, 1, 1, 1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R10 sticky hold", 64'(checkstop), 64'd1);
    doReset();
    check("R10 cleared by reset", 64'(checkstop), 64'd0);

    runCase("R7 addr err checkstop", 0, 0, 1, 0, 1, 0, 1, 1, 0, 0);
    doReset();
    runCase("R9 data err checkstop", 0, 0, 0, 1, 1, 0, 0, 0, 1, 1);
    doReset();

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      runCase("R7 R9 R5 random", 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom % 3 == 0), 1'($urandom),
              1'($urandom % 3 == 0), 1'($urandom), 1'($urandom % 3 == 0));
      if (csModel && ($urandom % 3 == 0)) doReset();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule